// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a system between four power states: Run, Sleep, Stop and Standby. A wait request (wait-for-interrupt or wait-for-event) starts the entry. The deep-sleep bit, the Standby select bit and the regulator and flash configuration bits choose the target state. From the current state the block drives several controls: the core clock and peripheral clock gates, the PLL, crystal-oscillator and RC-oscillator enables, the regulator on and low-power controls, flash power-down, the core-domain power switch and core reset, and the voltage-monitor run enable.

Each low-power state has its own set of wake sources and its own exit path:
- **Sleep** returns to Run on the next edge after an interrupt.
- **Stop** leaves on any enabled external event line. It first passes through a wake phase whose length grows by a parameter when the regulator was in low-power mode, and by a second parameter when flash was powered down. It then waits for the RC oscillator to report ready. The system clock returns on the RC oscillator, with the PLL and crystal held off until software drops its PLL request.
- **Standby** leaves on a wake-pin rising edge, any RTC event, or an external or watchdog reset request. The exit holds the core domain in reset and leaves a sticky standby flag that only a clear input or the block reset removes.

If a wake source that would end the target state is already pending when a wait request arrives, the entry is refused and the block stays in Run.

Top module: `lpm_seq`

## Requirements
- R1: After reset `mode_o` is 0 (Run). In that state the core clock, peripheral clock, PLL, crystal and RC oscillator enables, `reg_on` and `core_pwr_en` are 1. `reg_lp`, `flash_pd`, `core_rst` and `sb_flag` are 0, and `use_pll` equals `pll_sel_req`.
- R2: From Run, a wait request (`wfi_req` or `wfe_req`) is decoded on the next edge as follows:
  - with `deep_sel`=0, it enters Sleep (`mode_o`=1);
  - with `deep_sel`=1 and `standby_sel`=0, it enters Stop (`mode_o`=2);
  - with both set and `wfi_req`=1, it enters Standby (`mode_o`=4);
  - with both set and only `wfe_req`, it leaves the state at Run.
- R3: In Sleep the core clock is 0 while the peripheral clock and oscillators stay on. Sleep returns to Run on the edge where `irq_any` is 1, and an active event line does not end it.
- R4: In Stop all clocks and all three oscillator/PLL enables are 0, and `reg_on` and `core_pwr_en` stay 1. `reg_lp` and `flash_pd` show the values that `lp_reg_sel` and `flash_pd_sel` had on the entry edge.
- R5: Stop ends only when some bit of `evt_line & evt_en` is 1. A masked line and `irq_any` leave it in Stop.
- R6: A Stop exit goes through a wake phase (`mode_o`=3) and reaches Run D+2 edges after the exit edge, counting the exit edge. D is REG_WAKE when the latched regulator bit is set, plus FLASH_WAKE when the latched flash bit is set. The block stays in the wake phase while `osc_rdy` is 0.
- R7: After a Stop or Standby exit, `use_pll`, `pll_en` and `xosc_en` are 0 in Run even when `pll_sel_req` is 1. This lasts until an edge in Run sees `pll_sel_req` at 0.
- R8: In Standby (`mode_o`=4), `reg_on`, `core_pwr_en`, `vmon_run`, every clock and every oscillator enable are 0.
- R9: Standby ends on any of these: a rising edge of `wake_pin` while `wake_en` is 1, any bit of `rtc_evt`, `ext_rst_req`, or `wdg_rst_req`. An event line or a pin edge with `wake_en`=0 leaves it in Standby.
- R10: A Standby exit enters `mode_o`=5, with `core_rst` at 1 for RST_HOLD+1 cycles before Run. It sets `sb_flag`, which stays 1 until `sb_flag_clr` is 1 on an edge.
- R11: If the wake source of the target state is already active on the request edge, the request is refused and `mode_o` stays 0. For Sleep that source is `irq_any`, for Stop an enabled event line, and for Standby a Standby wake source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request |
| wfe_req | input | 1 | Wait-for-event request |
| deep_sel | input | 1 | Deep-sleep request bit |
| standby_sel | input | 1 | 1 selects Standby for deep sleep, 0 selects Stop |
| lp_reg_sel | input | 1 | Regulator in low-power mode during Stop |
| flash_pd_sel | input | 1 | Flash powered down during Stop |
| pll_sel_req | input | 1 | Software wants the PLL as system clock |
| vmon_on | input | 1 | Software enable of the supply voltage monitor |
| irq_any | input | 1 | Any enabled interrupt pending |
| evt_line | input | NEXTI | External event lines |
| evt_en | input | NEXTI | Per-line enable for Stop wakeup |
| wake_pin | input | 1 | Wake pin level |
| wake_en | input | 1 | Wake pin enable |
| rtc_evt | input | NRTC | RTC alarm, wakeup, tamper and time-stamp events |
| ext_rst_req | input | 1 | External reset request |
| wdg_rst_req | input | 1 | Watchdog reset request |
| osc_rdy | input | 1 | RC oscillator ready |
| sb_flag_clr | input | 1 | Clears the standby flag |
| mode_o | output | 3 | State code: 0 Run, 1 Sleep, 2 Stop, 3 Stop wake, 4 Standby, 5 Standby exit |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| pll_en | output | 1 | PLL enable |
| xosc_en | output | 1 | Crystal oscillator enable |
| rcosc_en | output | 1 | RC oscillator enable |
| reg_on | output | 1 | Main regulator on |
| reg_lp | output | 1 | Regulator low-power mode |
| flash_pd | output | 1 | Flash power-down |
| core_pwr_en | output | 1 | Core-domain power switch |
| core_rst | output | 1 | Core-domain reset |
| vmon_run | output | 1 | Voltage monitor running |
| use_pll | output | 1 | System clock taken from the PLL |
| sb_flag | output | 1 | Sticky resumed-from-Standby flag |

## Verification
The wait requests are applied with every combination of deep-sleep, Standby select and request type. This separates the three entry decodes and the refused wait-for-event Standby entry. Each low-power state is then hit with the wake sources of the other states to show that only its own sources end it. Stop exits are timed with the regulator and flash bits at (0,0), (1,1) and (1,0), which shows that each delay term is added on its own. One run holds the oscillator ready low to expose the ready wait. Standby exits are driven by the wake pin, an RTC event and the watchdog request. Pending sources at request time confirm that entry is refused.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      ST_RUN       = 3'd0,
      ST_SLEEP     = 3'd1,
      ST_STOP      = 3'd2,
      ST_STOP_WAKE = 3'd3,
      ST_STANDBY   = 3'd4,
      ST_SB_EXIT   = 3'd5
   } lpm_state_e;

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/lpm_wake_src.sv
module lpm_wake_src #(
   parameter int unsigned NEXTI       = 4,
   parameter int unsigned NRTC        = 5,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_any,
   input  logic [NEXTI-1:0] evt_line,
   input  logic [NEXTI-1:0] evt_en,
   input  logic             wake_pin,
   input  logic             wake_en,
   input  logic [NRTC-1:0]  rtc_evt,
   input  logic             ext_rst_req,
   input  logic             wdg_rst_req,
   output logic             sleep_hit,
   output logic             stop_hit,
   output logic             sb_hit
);
   localparam int unsigned RAW_W = NEXTI + NRTC + 3;

   logic [RAW_W-1:0] raw;
   logic [RAW_W-1:0] synced;
   logic             pin_q;
   logic [NEXTI-1:0] s_evt;
   logic [NRTC-1:0]  s_rtc;
   logic             s_ext, s_wdg, s_pin;

   assign raw = {evt_line, rtc_evt, ext_rst_req, wdg_rst_req, wake_pin};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = raw;
      end else begin : g_sync
         logic [RAW_W-1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign synced = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign {s_evt, s_rtc, s_ext, s_wdg, s_pin} = synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= s_pin;
   end

   assign sleep_hit = irq_any;
   assign stop_hit  = |(s_evt & evt_en);
   assign sb_hit    = (wake_en & s_pin & ~pin_q) | (|s_rtc) | s_ext | s_wdg;

   // R9
   pin_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_q && s_pin && !(|s_rtc) && !s_ext && !s_wdg) |-> !sb_hit)
      else $error("held wake pin level counted as a new edge");

endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R6
   wake_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero && !load) |=> (cnt == $past(cnt) - 1'b1))
      else $error("wake timer skipped a count");

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int unsigned NEXTI       = 4,
   parameter int unsigned NRTC        = 5,
   parameter int unsigned REG_WAKE    = 6,
   parameter int unsigned FLASH_WAKE  = 3,
   parameter int unsigned RST_HOLD    = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wfi_req,
   input  logic             wfe_req,
   input  logic             deep_sel,
   input  logic             standby_sel,
   input  logic             lp_reg_sel,
   input  logic             flash_pd_sel,
   input  logic             pll_sel_req,
   input  logic             vmon_on,
   input  logic             irq_any,
   input  logic [NEXTI-1:0] evt_line,
   input  logic [NEXTI-1:0] evt_en,
   input  logic             wake_pin,
   input  logic             wake_en,
   input  logic [NRTC-1:0]  rtc_evt,
   input  logic             ext_rst_req,
   input  logic             wdg_rst_req,
   input  logic             osc_rdy,
   input  logic             sb_flag_clr,
   output logic [2:0]       mode_o,
   output logic             core_clk_en,
   output logic             periph_clk_en,
   output logic             pll_en,
   output logic             xosc_en,
   output logic             rcosc_en,
   output logic             reg_on,
   output logic             reg_lp,
   output logic             flash_pd,
   output logic             core_pwr_en,
   output logic             core_rst,
   output logic             vmon_run,
   output logic             use_pll,
   output logic             sb_flag
);
   localparam int unsigned MAX_D = max3(REG_WAKE + FLASH_WAKE, RST_HOLD, 1);
   localparam int unsigned CNT_W = $clog2(MAX_D + 1) + 1;
   localparam logic [CNT_W-1:0] REG_D   = CNT_W'(REG_WAKE);
   localparam logic [CNT_W-1:0] FLASH_D = CNT_W'(FLASH_WAKE);
   localparam logic [CNT_W-1:0] HOLD_D  = CNT_W'(RST_HOLD);

   generate
      if (NEXTI < 1 || NEXTI > 64) begin : g_bad_nexti
         $error("NEXTI must lie in 1..64");
      end
      if (NRTC < 1 || NRTC > 16) begin : g_bad_nrtc
         $error("NRTC must lie in 1..16");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   lpm_state_e       state, state_nx;
   logic             sleep_hit, stop_hit, sb_hit;
   logic             lp_lat, fpd_lat;
   logic             force_rc;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             entry;

   lpm_wake_src #(.NEXTI(NEXTI), .NRTC(NRTC), .SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst_n(rst_n), .irq_any(irq_any),
      .evt_line(evt_line), .evt_en(evt_en),
      .wake_pin(wake_pin), .wake_en(wake_en), .rtc_evt(rtc_evt),
      .ext_rst_req(ext_rst_req), .wdg_rst_req(wdg_rst_req),
      .sleep_hit(sleep_hit), .stop_hit(stop_hit), .sb_hit(sb_hit)
   );

   lpm_wake_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   assign entry = wfi_req | wfe_req;

   // next state and timer load
   always_comb begin
      state_nx = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_RUN: begin
            if (entry) begin
               if (!deep_sel) begin
                  if (!sleep_hit) state_nx = ST_SLEEP;
               end else if (!standby_sel) begin
                  if (!stop_hit) state_nx = ST_STOP;
               end else if (wfi_req) begin
                  if (!sb_hit) state_nx = ST_STANDBY;
               end
            end
         end
         ST_SLEEP: if (sleep_hit) state_nx = ST_RUN;
         ST_STOP: begin
            if (stop_hit) begin
               state_nx = ST_STOP_WAKE;
               tmr_load = 1'b1;
               tmr_val  = (lp_lat ? REG_D : '0) + (fpd_lat ? FLASH_D : '0);
            end
         end
         ST_STOP_WAKE: if (tmr_zero && osc_rdy) state_nx = ST_RUN;
         ST_STANDBY: begin
            if (sb_hit) begin
               state_nx = ST_SB_EXIT;
               tmr_load = 1'b1;
               tmr_val  = HOLD_D;
            end
         end
         ST_SB_EXIT: if (tmr_zero && osc_rdy) state_nx = ST_RUN;
         default: state_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RUN;
         lp_lat   <= 1'b0;
         fpd_lat  <= 1'b0;
         force_rc <= 1'b0;
         sb_flag  <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_RUN && state_nx == ST_STOP) begin
            lp_lat  <= lp_reg_sel;
            fpd_lat <= flash_pd_sel;
         end
         if (state_nx == ST_STOP_WAKE || state_nx == ST_SB_EXIT)
            force_rc <= 1'b1;
         else if (state == ST_RUN && !pll_sel_req)
            force_rc <= 1'b0;
         if (state == ST_STANDBY && state_nx == ST_SB_EXIT)
            sb_flag <= 1'b1;
         else if (sb_flag_clr)
            sb_flag <= 1'b0;
      end
   end

   // output decode per state
   always_comb begin
      core_clk_en   = 1'b0;
      periph_clk_en = 1'b0;
      pll_en        = 1'b0;
      xosc_en       = 1'b0;
      rcosc_en      = 1'b0;
      reg_on        = 1'b1;
      reg_lp        = 1'b0;
      flash_pd      = 1'b0;
      core_pwr_en   = 1'b1;
      core_rst      = 1'b0;
      vmon_run      = vmon_on;
      use_pll       = 1'b0;
      unique case (state)
         ST_RUN, ST_SLEEP: begin
            core_clk_en   = (state == ST_RUN);
            periph_clk_en = 1'b1;
            pll_en        = ~force_rc;
            xosc_en       = ~force_rc;
            rcosc_en      = 1'b1;
            use_pll       = pll_sel_req & ~force_rc;
         end
         ST_STOP: begin
            reg_lp   = lp_lat;
            flash_pd = fpd_lat;
         end
         ST_STOP_WAKE: rcosc_en = 1'b1;
         ST_STANDBY: begin
            reg_on      = 1'b0;
            core_pwr_en = 1'b0;
            vmon_run    = 1'b0;
         end
         ST_SB_EXIT: begin
            rcosc_en = 1'b1;
            core_rst = 1'b1;
            vmon_run = 1'b0;
         end
         default: ;
      endcase
   end

   assign mode_o = state;

   // R3
   sleep_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd1) |-> (!core_clk_en && periph_clk_en))
      else $error("Sleep gating wrong");

   // R4
   stop_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd2) |-> !(pll_en || xosc_en || rcosc_en || periph_clk_en || core_clk_en))
      else $error("clock or oscillator alive in Stop");

   // R8
   standby_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_pwr_en |-> (!reg_on && !vmon_run && !core_clk_en))
      else $error("Standby power state inconsistent");

   // R10
   sb_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_flag && !sb_flag_clr) |=> sb_flag)
      else $error("standby flag lost");

   // R7
   rc_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == 3'd3 && mode_o == 3'd0) |-> (!use_pll && !pll_en))
      else $error("PLL used right after Stop exit");

   // R11
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd0 && wfi_req && !deep_sel && irq_any) |=> (mode_o == 3'd0))
      else $error("Sleep entered with interrupt pending");

endmodule

// File: tb/lpm_seq_test.sv
`timescale 1ns/1ps
module lpm_seq_test;
   localparam int NEXTI = 4, NRTC = 5, REG_WAKE = 6, FLASH_WAKE = 3, RST_HOLD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wfi_req = 0, wfe_req = 0, deep_sel = 0, standby_sel = 0;
   logic lp_reg_sel = 0, flash_pd_sel = 0, pll_sel_req = 1, vmon_on = 1, irq_any = 0;
   logic [NEXTI-1:0] evt_line = '0, evt_en = '0;
   logic wake_pin = 0, wake_en = 0;
   logic [NRTC-1:0] rtc_evt = '0;
   logic ext_rst_req = 0, wdg_rst_req = 0, osc_rdy = 1, sb_flag_clr = 0;
   logic [2:0] mode_o;
   logic core_clk_en, periph_clk_en, pll_en, xosc_en, rcosc_en, reg_on, reg_lp;
   logic flash_pd, core_pwr_en, core_rst, vmon_run, use_pll, sb_flag;

   always #5 clk = ~clk;

   lpm_seq #(.NEXTI(NEXTI), .NRTC(NRTC), .REG_WAKE(REG_WAKE), .FLASH_WAKE(FLASH_WAKE),
             .RST_HOLD(RST_HOLD), .SYNC_STAGES(0)) uut (
      .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
      .deep_sel(deep_sel), .standby_sel(standby_sel), .lp_reg_sel(lp_reg_sel),
      .flash_pd_sel(flash_pd_sel), .pll_sel_req(pll_sel_req), .vmon_on(vmon_on),
      .irq_any(irq_any), .evt_line(evt_line), .evt_en(evt_en), .wake_pin(wake_pin),
      .wake_en(wake_en), .rtc_evt(rtc_evt), .ext_rst_req(ext_rst_req),
      .wdg_rst_req(wdg_rst_req), .osc_rdy(osc_rdy), .sb_flag_clr(sb_flag_clr),
      .mode_o(mode_o), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
      .pll_en(pll_en), .xosc_en(xosc_en), .rcosc_en(rcosc_en), .reg_on(reg_on),
      .reg_lp(reg_lp), .flash_pd(flash_pd), .core_pwr_en(core_pwr_en),
      .core_rst(core_rst), .vmon_run(vmon_run), .use_pll(use_pll), .sb_flag(sb_flag)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      string       req;
      logic [2:0]  mode;
      logic [12:0] outs;
   } item_t;

   item_t sb_q[$];
   event  pushed;

   // expectation state kept by the bench
   bit frc = 0, sbf = 0;

   function automatic logic [12:0] exp_o(int m, bit lp, bit fpd);
      bit pv, pu;
      pv = vmon_on;
      pu = pll_sel_req & ~frc;
      case (m)
         0: return {1'b1, 1'b1, ~frc, ~frc, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, pv, pu, sbf};
         1: return {1'b0, 1'b1, ~frc, ~frc, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, pv, pu, sbf};
         2: return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, lp, fpd, 1'b1, 1'b0, pv, 1'b0, sbf};
         3: return {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, pv, 1'b0, sbf};
         4: return {12'b0, sbf};
         default: return {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, sbf};
      endcase
   endfunction

   function automatic logic [12:0] act_o();
      return {core_clk_en, periph_clk_en, pll_en, xosc_en, rcosc_en, reg_on, reg_lp,
              flash_pd, core_pwr_en, core_rst, vmon_run, use_pll, sb_flag};
   endfunction

   // driver side: push expected item for the current cycle
   task automatic expect_st(string req, int m, bit lp = 0, bit fpd = 0);
      item_t it;
      it.req  = req;
      it.mode = 3'(m);
      it.outs = exp_o(m, lp, fpd);
      sb_q.push_back(it);
      -> pushed;
      #1;
   endtask

   // monitor side: pop and compare against the outputs
   initial begin
      forever begin
         @(pushed);
         while (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (mode_o !== it.mode) begin
               errors++;
               $display("FAIL %s mode: actual %0d expected %0d", it.req, mode_o, it.mode);
            end
            checks++;
            if (act_o() !== it.outs) begin
               errors++;
               $display("FAIL %s outputs: actual %b expected %b", it.req, act_o(), it.outs);
            end
         end
      end
   end

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // apply a one-cycle wait request; the state after the edge is observed
   task automatic request(bit wfi, bit wfe);
      @(negedge clk);
      wfi_req = wfi;
      wfe_req = wfe;
      tick();
      @(negedge clk);
      wfi_req = 0;
      wfe_req = 0;
   endtask

   // edges until Run, counting the edge that sees the wake source
   task automatic run_latency(output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while (mode_o != 3'd0 && n < 60);
   endtask

   task automatic clear_force();
      @(negedge clk) pll_sel_req = 0;
      tick();
      frc = 0;
      @(negedge clk) pll_sel_req = 1;
      tick();
   endtask

   initial begin
      int n;
      int rst_cycles;
      repeat (3) @(posedge clk);
      #1;
      expect_st("R1 reset in run", 0);
      @(negedge clk) rst_n = 1;
      tick();
      expect_st("R1 run after release", 0);

      // Sleep entry, ignored event line, interrupt exit
      request(1, 0);
      expect_st("R2 wfi shallow enters sleep", 1);
      evt_en = 4'b0001; evt_line = 4'b0001;
      tick();
      expect_st("R3 event line does not end sleep", 1);
      evt_line = '0; evt_en = '0;
      @(negedge clk) irq_any = 1;
      tick();
      expect_st("R3 interrupt ends sleep", 0);

      // pending interrupt refuses sleep (irq still high)
      request(1, 0);
      expect_st("R11 pending irq keeps run", 0);
      irq_any = 0;

      // Stop, no extra delays
      deep_sel = 1; standby_sel = 0; lp_reg_sel = 0; flash_pd_sel = 0;
      request(0, 1);
      expect_st("R2 wfe deep enters stop", 2, 0, 0);
      irq_any = 1;
      evt_en = 4'b0100; evt_line = 4'b0010;
      tick();
      expect_st("R5 irq and masked line keep stop", 2, 0, 0);
      irq_any = 0;
      @(negedge clk) evt_line = 4'b0100;
      run_latency(n);
      chk("R6 stop exit latency D=0", n, 2);
      evt_line = '0;
      frc = 1;
      expect_st("R7 rc clock forced after stop", 0);
      @(negedge clk) pll_sel_req = 0;
      tick();
      frc = 0;
      expect_st("R7 force cleared by dropped pll request", 0);
      @(negedge clk) pll_sel_req = 1;
      tick();
      expect_st("R7 pll usable again", 0);

      // pending event line refuses stop
      evt_line = 4'b0100;
      request(1, 0);
      expect_st("R11 pending event keeps run", 0);
      evt_line = '0;

      // Stop with low-power regulator and flash down
      lp_reg_sel = 1; flash_pd_sel = 1;
      request(1, 0);
      expect_st("R4 stop latches lp and flash bits", 2, 1, 1);
      @(negedge clk) begin lp_reg_sel = 0; flash_pd_sel = 0; end
      tick();
      expect_st("R4 latched bits hold after inputs change", 2, 1, 1);
      @(negedge clk) evt_line = 4'b0100;
      run_latency(n);
      chk("R6 stop exit latency D=REG+FLASH", n, REG_WAKE + FLASH_WAKE + 2);
      evt_line = '0;
      frc = 1;
      clear_force();

      // Stop with low-power regulator only, oscillator slow
      lp_reg_sel = 1; flash_pd_sel = 0;
      request(1, 0);
      expect_st("R4 stop with lp only", 2, 1, 0);
      @(negedge clk) begin evt_line = 4'b0100; osc_rdy = 0; end
      run_latency(n);
      chk("R6 wake waits for oscillator", n, 60);
      expect_st("R6 still in stop wake", 3);
      @(negedge clk) osc_rdy = 1;
      tick();
      frc = 1;
      expect_st("R6 run once oscillator ready", 0);
      evt_line = '0;
      clear_force();
      @(negedge clk) osc_rdy = 0;
      osc_rdy = 1;
      request(1, 0);
      @(negedge clk) evt_line = 4'b0100;
      run_latency(n);
      chk("R6 stop exit latency D=REG", n, REG_WAKE + 2);
      evt_line = '0;
      frc = 1;
      clear_force();

      // wfe with Standby selected is ignored
      standby_sel = 1;
      request(0, 1);
      expect_st("R2 wfe cannot enter standby", 0);

      // Standby via wake pin
      wake_en = 0; wake_pin = 0;
      request(1, 0);
      expect_st("R8 standby power off", 4);
      evt_en = 4'b0001; evt_line = 4'b0001;
      tick();
      expect_st("R9 event line ignored in standby", 4);
      evt_line = '0;
      @(negedge clk) wake_pin = 1;
      tick();
      expect_st("R9 disabled pin edge ignored", 4);
      @(negedge clk) wake_pin = 0;
      tick();
      @(negedge clk) begin wake_en = 1; wake_pin = 1; end
      tick();
      sbf = 1;
      expect_st("R10 standby exit holds core reset", 5);
      rst_cycles = 1;
      while (core_rst && rst_cycles < 40) begin
         tick();
         if (core_rst) rst_cycles++;
      end
      chk("R10 core reset length", rst_cycles, RST_HOLD + 1);
      frc = 1;
      expect_st("R10 run with flag set after standby", 0);
      wake_pin = 0;
      clear_force();
      @(negedge clk) sb_flag_clr = 1;
      tick();
      sbf = 0;
      expect_st("R10 flag cleared", 0);
      sb_flag_clr = 0;

      // Standby via RTC event
      request(1, 0);
      expect_st("R8 standby again", 4);
      @(negedge clk) rtc_evt = 5'b00100;
      tick();
      sbf = 1;
      expect_st("R9 rtc event ends standby", 5);
      rtc_evt = '0;
      run_latency(n);
      chk("R10 standby exit to run", n, RST_HOLD + 1);
      frc = 1;
      clear_force();

      // Standby via watchdog, then refused entry with pending RTC event
      request(1, 0);
      @(negedge clk) wdg_rst_req = 1;
      tick();
      expect_st("R9 watchdog ends standby", 5);
      wdg_rst_req = 0;
      run_latency(n);
      frc = 1;
      clear_force();
      rtc_evt = 5'b00001;
      request(1, 0);
      expect_st("R11 pending rtc keeps run", 0);
      rtc_evt = '0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule